// File: doc/BRIEF.md
# Trace Port Clock and Frame-Rate Generator

This block derives the timing of an outgoing trace port from the processor clock. It produces a one-cycle frame strobe that tells the trace packetizer when to present a new data frame, together with the trace clock that travels with the data to an external capture tool. The frame length is one processor cycle in full-speed operation. In low-speed operation it is set by a divider field, and a divider of zero is treated as a divide-by-two.

The trace clock is built so that the tool's sampling edge falls as near as possible to the centre of each data frame. In single-edge mode the clock rises at the frame midpoint and falls at the frame boundary. In double-edge mode it runs at half the frame rate and changes level once per frame, at that frame's midpoint, so the tool samples on both edges. Both edges are placed to half-cycle resolution, so odd frame lengths are centred exactly.

Configuration inputs may change at any time. They are captured only at a frame boundary, so no frame is ever cut short. Reset is synchronous and active low.

Top module: `trace_clk_gen`

## Requirements
- R1: With `lowSpeed` = 0 the frame length is one processor cycle, so `frameStb` is 1 in every cycle once running.
- R2: With `lowSpeed` = 1 and `divSel` = D with D ≥ 1, consecutive `frameStb` pulses are exactly D+1 cycles apart.
- R3: With `lowSpeed` = 1 and `divSel` = 0, consecutive `frameStb` pulses are exactly 2 cycles apart.
- R4: With `ddrMode` = 0 and a frame length of N cycles, split into 2N half-cycles numbered from 0 (half-cycle 2k is the high phase of the k-th processor cycle and 2k+1 its low phase), `traceClk` is 0 in half-cycles below N and 1 from half-cycle N onward.
- R5: With `ddrMode` = 1, `traceClk` changes level only at half-cycle N of each frame. It therefore completes one period every two frames, and its level carries across a boundary between two double-edge frames. A double-edge frame that follows reset or a single-edge frame starts at 0.
- R6: With `lowSpeed` = 0 and `ddrMode` = 0, `traceClk` is the inverse of `clk`.
- R7: `lowSpeed`, `divSel` and `ddrMode` are sampled only at the clock edge that starts a frame, which is the edge after which `frameStb` is 1. A change during a frame alters neither that frame's length nor its clock pattern.
- R8: While `rstN` is 0, `frameStb` and `traceClk` are both 0 after every clock edge.
- R9: After reset is released with a configuration giving frame length N, `frameStb` is first 1 in the cycle after the N-th rising edge. `traceClk` stays 0 until that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Synchronous reset, active low |
| lowSpeed | input | 1 | 1 selects the divided frame rate |
| divSel | input | DIV_W | Frame divider; length divSel+1, with 0 meaning 2 |
| ddrMode | input | 1 | 1 makes the tool sample on both trace clock edges |
| frameStb | output | 1 | High in the first cycle of each data frame |
| traceClk | output | 1 | Outgoing trace clock, placed at half-cycle resolution |

## Verification
Every result is registered. The strobe for a frame, and the configuration that frame uses, both appear in the cycle that follows the rising edge that starts the frame. The trace clock's level for each half of a processor cycle is fixed by that same edge. The bench therefore drives inputs three quarters of the way through a cycle, well clear of the next rising edge. It reads `frameStb` and the high-phase level of `traceClk` a quarter cycle after the edge, and the low-phase level three quarters after it. Expected values come from a frame schedule kept by the bench. That schedule takes its configuration from the inputs present at each edge where a strobe is due, and it models the double-edge clock as a level that toggles at each frame's midpoint.

// File: rtl/tcg_pkg.sv
`timescale 1ns/1ps
package tcg_pkg;

  // Strobes handed from the frame controller to the level datapath.
  typedef struct packed {
    logic frameEnd;  // current cycle is the last of its frame
    logic liveNow;   // first real frame has already started
    logic liveNext;  // running after the coming edge
    logic ddrNow;    // mode of the frame in progress
    logic ddrNext;   // mode of the frame after the coming edge
  } tcgStrobe_t;

endpackage

// File: rtl/tcg_frame_ctrl.sv
`timescale 1ns/1ps
module tcg_frame_ctrl
  import tcg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lowSpeed,
  input  logic [DIV_W-1:0] divSel,
  input  logic             ddrMode,
  output tcgStrobe_t       strobes,
  output logic [DIV_W:0]   posNext,
  output logic [DIV_W:0]   lenNext,
  output logic [DIV_W:0]   lenNow,
  output logic             ddrNow,
  output logic             liveNow
);

  localparam int LEN_W = DIV_W + 1;
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_TWO = LEN_W'(2);

  logic [LEN_W-1:0] posCnt;
  logic [LEN_W-1:0] curLen;
  logic             curDdr;
  logic             started;
  logic [LEN_W-1:0] reqLen;
  logic             atEnd;

  // Length requested by the inputs; divider zero is a divide-by-two.
  always_comb begin
    if (!lowSpeed) begin
      reqLen = LEN_ONE;
    end else if (divSel == '0) begin
      reqLen = LEN_TWO;
    end else begin
      reqLen = LEN_W'(divSel) + LEN_ONE;
    end
  end

  assign atEnd = (posCnt == curLen - LEN_ONE);

  always_comb begin
    if (atEnd) begin
      posNext = '0;
      lenNext = reqLen;
    end else begin
      posNext = posCnt + LEN_ONE;
      lenNext = curLen;
    end
  end

  // During reset the configuration follows the inputs so that the
  // lead-in frame already has the requested length.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      posCnt  <= '0;
      curLen  <= reqLen;
      curDdr  <= ddrMode;
      started <= 1'b0;
    end else begin
      posCnt <= posNext;
      if (atEnd) begin
        curLen  <= reqLen;
        curDdr  <= ddrMode;
        started <= 1'b1;
      end
    end
  end

  always_comb begin
    strobes.frameEnd = atEnd;
    strobes.liveNow  = started;
    strobes.liveNext = started | atEnd;
    strobes.ddrNow   = curDdr;
    strobes.ddrNext  = atEnd ? ddrMode : curDdr;
  end

  assign lenNow  = curLen;
  assign ddrNow  = curDdr;
  assign liveNow = started;

endmodule

// File: rtl/tcg_level_path.sv
`timescale 1ns/1ps
module tcg_level_path
  import tcg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  tcgStrobe_t     strobes,
  input  logic [DIV_W:0] posNext,
  input  logic [DIV_W:0] lenNext,
  output logic           frameStb,
  output logic           levelHi,
  output logic           levelLo,
  output logic           traceClk
);

  localparam int LEN_W  = DIV_W + 1;
  localparam int HALF_W = LEN_W + 1;

  logic [HALF_W-1:0] halfHi;
  logic [HALF_W-1:0] halfLo;
  logic [HALF_W-1:0] halfMid;
  logic              pastMidHi;
  logic              pastMidLo;
  logic              phase;
  logic              phaseNext;
  logic              nextHi;
  logic              nextLo;
  logic              stbQ;
  logic              hiQ;
  logic              loQ;

  // Half-cycle index of the two phases of the coming cycle.
  assign halfHi    = {posNext, 1'b0};
  assign halfLo    = {posNext, 1'b1};
  assign halfMid   = {1'b0, lenNext};
  assign pastMidHi = (halfHi >= halfMid);
  assign pastMidLo = (halfLo >= halfMid);

  // Double-edge phase: flips per frame while double-edge frames follow
  // each other, otherwise restarts so the new frame opens low.
  always_comb begin
    phaseNext = phase;
    if (strobes.frameEnd) begin
      if (strobes.ddrNext && strobes.ddrNow && strobes.liveNow) begin
        phaseNext = ~phase;
      end else begin
        phaseNext = 1'b1;
      end
    end
  end

  always_comb begin
    if (!strobes.liveNext) begin
      nextHi = 1'b0;
      nextLo = 1'b0;
    end else if (strobes.ddrNext) begin
      nextHi = pastMidHi ? phaseNext : ~phaseNext;
      nextLo = pastMidLo ? phaseNext : ~phaseNext;
    end else begin
      nextHi = pastMidHi;
      nextLo = pastMidLo;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stbQ  <= 1'b0;
      hiQ   <= 1'b0;
      loQ   <= 1'b0;
      phase <= 1'b0;
    end else begin
      stbQ  <= strobes.frameEnd;
      hiQ   <= nextHi;
      loQ   <= nextLo;
      phase <= phaseNext;
    end
  end

  assign frameStb = stbQ;
  assign levelHi  = hiQ;
  assign levelLo  = loQ;
  // Level pair selected by the clock phase gives half-cycle placement.
  assign traceClk = clk ? hiQ : loQ;

endmodule

// File: rtl/trace_clk_gen.sv
`timescale 1ns/1ps
module trace_clk_gen
  import tcg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lowSpeed,
  input  logic [DIV_W-1:0] divSel,
  input  logic             ddrMode,
  output logic             frameStb,
  output logic             traceClk
);

  tcgStrobe_t     strobes;
  logic [DIV_W:0] posNext;
  logic [DIV_W:0] lenNext;
  logic [DIV_W:0] curLen;
  logic           curDdr;
  logic           live;
  logic           lvA;
  logic           lvB;

  tcg_frame_ctrl #(.DIV_W(DIV_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lowSpeed (lowSpeed),
    .divSel   (divSel),
    .ddrMode  (ddrMode),
    .strobes  (strobes),
    .posNext  (posNext),
    .lenNext  (lenNext),
    .lenNow   (curLen),
    .ddrNow   (curDdr),
    .liveNow  (live)
  );

  tcg_level_path #(.DIV_W(DIV_W)) i_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .posNext  (posNext),
    .lenNext  (lenNext),
    .frameStb (frameStb),
    .levelHi  (lvA),
    .levelLo  (lvB),
    .traceClk (traceClk)
  );

endmodule

// File: rtl/tcg_checker.sv
`timescale 1ns/1ps
module tcg_checker #(
  parameter int DIV_W = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           frameStb,
  input logic [DIV_W:0] curLen,
  input logic           curDdr,
  input logic           live,
  input logic           lvA,
  input logic           lvB
);

  logic [DIV_W+1:0] gap;
  logic [DIV_W:0]   prevLen;
  logic             seenStb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gap     <= '0;
      prevLen <= '0;
      seenStb <= 1'b0;
    end else if (frameStb) begin
      gap     <= (DIV_W+2)'(1);
      prevLen <= curLen;
      seenStb <= 1'b1;
    end else begin
      gap <= gap + (DIV_W+2)'(1);
    end
  end

  // R8: reset leaves strobe and both clock levels low
  p_reset_quiet_r8: assert property (@(posedge clk)
    !rstN |=> (!frameStb && !lvA && !lvB));

  // R2 (also R1, R3): strobe spacing equals the length of the frame it closes
  p_frame_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    (frameStb && seenStb) |-> (gap == {1'b0, prevLen}));

  // R4: a single-edge frame opens low in its first half-cycle
  p_sdr_open_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (frameStb && !curDdr) |-> (!lvA && (lvB == (curLen == 1))));

  // R5: level carries across a boundary between double-edge frames
  p_ddr_carry_r5: assert property (@(posedge clk) disable iff (!rstN)
    (frameStb && curDdr && $past(curDdr)) |-> (lvA == $past(lvB)));

  // R6: full-rate single-edge output is the inverted processor clock
  p_inv_clk_r6: assert property (@(posedge clk) disable iff (!rstN)
    (live && (curLen == 1) && !curDdr) |-> (!lvA && lvB));

  // R9: nothing leaves the block before the first frame starts
  p_lead_in_r9: assert property (@(posedge clk) disable iff (!rstN)
    !live |-> (!frameStb && !lvA && !lvB));

endmodule

bind trace_clk_gen tcg_checker #(.DIV_W(DIV_W)) i_tcg_checker (
  .clk      (clk),
  .rstN     (rstN),
  .frameStb (frameStb),
  .curLen   (curLen),
  .curDdr   (curDdr),
  .live     (live),
  .lvA      (lvA),
  .lvB      (lvB)
);

// File: tb/test_trace_clk_gen.sv
`timescale 1ns/1ps
module test_trace_clk_gen;

  localparam int CLK_PERIOD = 8;
  localparam int DIV_W      = 8;
  localparam int WATCHDOG   = 200000;

  logic             clk;
  logic             rstN;
  logic             lowSpeed;
  logic [DIV_W-1:0] divSel;
  logic             ddrMode;
  logic             frameStb;
  logic             traceClk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Bench frame schedule
  int fpos;
  int fLen;
  bit fDdr;
  bit fDiv0;
  bit mLive;
  bit mLevel;
  bit expStb;

  trace_clk_gen #(.DIV_W(DIV_W)) i_trace_clk_gen (
    .clk      (clk),
    .rstN     (rstN),
    .lowSpeed (lowSpeed),
    .divSel   (divSel),
    .ddrMode  (ddrMode),
    .frameStb (frameStb),
    .traceClk (traceClk)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int lenOf(bit ls, int div);
    if (!ls) return 1;
    if (div == 0) return 2;
    return div + 1;
  endfunction

  function automatic bit sdrLevel(int pos, int half, int len);
    return (2 * pos + half) >= len;
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string stbTag();
    if (!mLive && !expStb) return "R9";
    if (lenOf(lowSpeed, int'(divSel)) != fLen || ddrMode != fDdr) return "R7";
    if (fLen == 1) return "R1";
    if (fDiv0) return "R3";
    return "R2";
  endfunction

  function automatic string clkTag();
    if (!mLive) return "R9";
    if (fDdr) return "R5";
    if (fLen == 1) return "R6";
    return "R4";
  endfunction

  task automatic checkHalf(bit inRst, int half);
    logic exp;
    if (inRst) begin
      check("R8", "traceClk in reset", traceClk, 1'b0);
      return;
    end
    if (!mLive) begin
      exp = 1'b0;
    end else if (!fDdr) begin
      exp = sdrLevel(fpos, half, fLen);
    end else begin
      if (2 * fpos + half == fLen) mLevel = ~mLevel;
      exp = mLevel;
    end
    check(clkTag(), half == 0 ? "traceClk high phase" : "traceClk low phase",
          traceClk, exp);
  endtask

  // One processor cycle: advance the schedule at the edge, sample a quarter
  // and three quarters of the way through, return at the three-quarter point.
  task automatic runCycle();
    bit inRst;
    bit newDdr;
    @(posedge clk);
    inRst = !rstN;
    if (inRst) begin
      fpos   = 0;
      fLen   = lenOf(lowSpeed, int'(divSel));
      fDdr   = ddrMode;
      fDiv0  = lowSpeed && divSel == 0;
      mLive  = 0;
      mLevel = 0;
      expStb = 0;
    end else begin
      expStb = (fpos == fLen - 1);
      if (expStb) begin
        newDdr = ddrMode;
        if (!(mLive && fDdr && newDdr)) mLevel = 0;
        fpos  = 0;
        fLen  = lenOf(lowSpeed, int'(divSel));
        fDiv0 = lowSpeed && divSel == 0;
        fDdr  = newDdr;
        mLive = 1;
      end else begin
        fpos++;
      end
    end
    #(CLK_PERIOD/4);
    if (inRst) check("R8", "frameStb in reset", frameStb, 1'b0);
    else       check(stbTag(), "frameStb", frameStb, expStb);
    checkHalf(inRst, 0);
    #(CLK_PERIOD/2);
    checkHalf(inRst, 1);
  endtask

  task automatic setCfg(bit ls, int div, bit ddr);
    lowSpeed = ls;
    divSel   = DIV_W'(div);
    ddrMode  = ddr;
  endtask

  task automatic runFor(int n);
    for (int i = 0; i < n; i++) runCycle();
  endtask

  task automatic resetWith(bit ls, int div, bit ddr, int cycles);
    rstN = 1'b0;
    setCfg(ls, div, ddr);
    runFor(cycles);
    rstN = 1'b1;
  endtask

  initial begin
    int firstStbCycle;
    rstN = 1'b0;
    setCfg(1, 4, 0);
    void'($urandom(32'd1234));

    // R8 then R9: divide-by-five lead-in, first strobe after edge five
    runFor(4);
    rstN = 1'b1;
    firstStbCycle = 0;
    for (int i = 1; i <= 7; i++) begin
      runCycle();
      if (frameStb === 1'b1 && firstStbCycle == 0) firstStbCycle = i;
    end
    checks++;
    if (firstStbCycle != 5) begin
      errors++;
      $display("FAIL R9 first strobe cycle: actual %0d expected %0d", firstStbCycle, 5);
    end

    // Directed corner cases
    setCfg(0, 0, 0);   runFor(20);   // R1, R6
    setCfg(1, 0, 0);   runFor(20);   // R3
    setCfg(1, 1, 0);   runFor(20);   // R2 length two
    setCfg(1, 2, 0);   runFor(24);   // R4 odd length, mid half-cycle rise
    setCfg(1, 2, 1);   runFor(24);   // R5 odd length, double edge
    setCfg(0, 0, 1);   runFor(20);   // R5 full rate, double edge
    setCfg(1, 7, 1);   runFor(40);   // R5 long frames
    setCfg(1, 0, 1);   runFor(12);   // R5 entering from another length
    setCfg(1, 9, 0);   runFor(13);   // R7 long frame, then change mid-frame
    setCfg(0, 0, 0);   runFor(30);
    setCfg(1, 3, 0);   runFor(2);    // R7 changes inside one frame
    setCfg(1, 5, 1);   runFor(1);
    setCfg(0, 0, 0);   runFor(20);

    // Reset in the middle of running, double edge, length three
    resetWith(1, 2, 1, 3);
    runFor(30);

    // Constrained random segment
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(15) == 0) begin
        setCfg(1'($urandom_range(1)),
               ($urandom_range(7) == 0) ? int'($urandom_range(255)) : int'($urandom_range(5)),
               1'($urandom_range(1)));
      end
      runCycle();
    end

    // Longest frame once
    setCfg(1, 255, 1);
    runFor(600);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule